// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Combiner

This block gathers up to 64 level-type interrupt request lines from on-chip peripherals into one raw status vector. It combines that vector with a software-owned enable mask to form the pending set. When any source is pending, it raises a single registered summary request to the processor. Alongside the summary request it offers a next-source index so that the handler does not have to scan bits. A rotating search chooses this index, so no source can starve another.

The search starts at a stored pointer and walks upward through the pending set, wrapping at the top. The pointer moves only when the processor pulses `serviced`. It then lands one place past the index that was just reported. A contiguous, inclusive window of source numbers can be declared as cascaded external lines. When the chosen index falls inside the window, the block flags it and also reports the index rebased to the window start.

Software reaches the status and mask through a small word-wide register port. The mask can be written a whole word at a time, or one bit can be set or cleared by number without touching the others. The source count must be 32 or 64.

Top module: `rr_intr_combiner`

## Requirements
- R1: The pending set is `src_status & mask`. A source whose mask bit is 0 is never reported by `idx_valid`/`idx` and does not raise `irq_out`.
- R2: `irq_out` is the OR of the pending set, registered, so it follows the pending set with one clock of latency.
- R3: A synchronous reset clears the mask to all zeros, the round-robin pointer to 0, `irq_out` to 0 and `reg_rdata` to 0.
- R4: While nothing is pending, `idx_valid` is 0 and a `serviced` pulse leaves the pointer unchanged.
- R5: With something pending, `idx_valid` is 1 and `idx` is the first pending source found by scanning upward from the pointer, wrapping from SRC_W-1 to 0. No source has fixed priority.
- R6: A `serviced` pulse while `idx_valid` is 1 sets the pointer to `idx`+1 modulo SRC_W, so after source SRC_W-1 is serviced the search starts again at 0.
- R7: The pointer moves only on `serviced`. Without that pulse, repeated looks at an unchanged pending set give the same `idx`.
- R8: With CASC_EN=1 and `idx` in the inclusive window [CASC_LO, CASC_HI], `idx_is_ext` is 1 and `ext_num` = `idx` - CASC_LO. Otherwise both are 0.
- R9: A write to address 2 loads mask bits 31:0 from `reg_wdata`, and a write to address 3 loads mask bits 63:32. When SRC_W=32, address 3 writes are ignored and it reads as 0.
- R10: A write to address 4 sets, and a write to address 5 clears, the single mask bit numbered by `reg_wdata[IDX_W-1:0]`. All other mask bits keep their values.
- R11: `reg_rdata` is registered. One clock after `reg_addr` is presented, it shows status bits 31:0 (address 0), status bits 63:32 (address 1), mask bits 31:0 (address 2) or mask bits 63:32 (address 3). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_status | input | SRC_W | Raw level interrupt status, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| serviced | input | 1 | One-cycle pulse: the reported source was handled, so advance the pointer |
| irq_out | output | 1 | Registered summary interrupt |
| idx_valid | output | 1 | A source is pending and `idx` is meaningful |
| idx | output | IDX_W | Next source chosen by round-robin |
| idx_is_ext | output | 1 | Chosen source lies in the cascaded window |
| ext_num | output | IDX_W | Chosen index rebased to the window start |

## Verification
The round-robin pointer cannot be seen at the ports, so every claim about it has to be inferred from the index that follows a chosen sequence of pending patterns and `serviced` pulses. The hardest case is the wrap: the pointer must sit above source 0 while both the top source and source 0 are pending, so that the top source is picked first and its service sends the search back to 0. The stimulus table gets there by servicing low sources until the pointer passes them, then offering bits 63 and 0 together. It repeats that pattern to show that 0 follows. A later reset checks that the pointer has returned to 0.

// File: rtl/rr_irq_pkg.sv
package rr_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STAT_LO = 3'd0,
    ADR_STAT_HI = 3'd1,
    ADR_MASK_LO = 3'd2,
    ADR_MASK_HI = 3'd3,
    ADR_BIT_SET = 3'd4,
    ADR_BIT_CLR = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/rr_mask_regs.sv
module rr_mask_regs
  import rr_irq_pkg::*;
#(
  parameter int SRC_W = 64,
  localparam int IDX_W = $clog2(SRC_W),
  localparam int NWORD = SRC_W / REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [SRC_W-1:0]  status,
  output logic [SRC_W-1:0]  mask,
  output logic [REG_W-1:0]  rdata
);
  logic [SRC_W-1:0] mask_q, mask_d;
  logic [REG_W-1:0] rd_q, rd_d;
  logic [IDX_W-1:0] bit_sel;

  assign bit_sel = wdata[IDX_W-1:0];

  always_comb begin
    mask_d = mask_q;
    if (wr) begin
      for (int w = 0; w < NWORD; w++) begin
        if (addr == ADDR_W'(ADR_MASK_LO + w))
          mask_d[w*REG_W +: REG_W] = wdata;
      end
      if (addr == ADR_BIT_SET) mask_d[bit_sel] = 1'b1;
      if (addr == ADR_BIT_CLR) mask_d[bit_sel] = 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (addr == ADDR_W'(ADR_STAT_LO + w)) rd_d = status[w*REG_W +: REG_W];
      if (addr == ADDR_W'(ADR_MASK_LO + w)) rd_d = mask_q[w*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rd_q   <= '0;
    end else begin
      mask_q <= mask_d;
      rd_q   <= rd_d;
    end
  end

  assign mask  = mask_q;
  assign rdata = rd_q;
endmodule

// File: rtl/rr_rotate_pick.sv
module rr_rotate_pick #(
  parameter int SRC_W = 64,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] pend,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  logic [2*SRC_W-1:0] dbl;
  logic [SRC_W-1:0]   rot;
  logic [IDX_W-1:0]   off;

  assign dbl = {pend, pend} >> start;
  assign rot = dbl[SRC_W-1:0];

  // lowest set bit of the rotated vector = distance from the pointer
  always_comb begin
    off = '0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (rot[i]) off = IDX_W'(i);
    end
  end

  assign found = |pend;
  assign pick  = start + off;
endmodule

// File: rtl/rr_casc_remap.sv
module rr_casc_remap #(
  parameter int SRC_W   = 64,
  parameter bit CASC_EN = 1'b1,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 13,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] sel,
  output logic             is_ext,
  output logic [IDX_W-1:0] ext_num
);
  localparam logic [IDX_W-1:0] LO = IDX_W'(CASC_LO);
  localparam logic [IDX_W-1:0] HI = IDX_W'(CASC_HI);

  generate
    if (CASC_EN) begin : g_casc
      logic in_win;
      assign in_win  = valid && (sel >= LO) && (sel <= HI);
      assign is_ext  = in_win;
      assign ext_num = in_win ? (sel - LO) : '0;
    end else begin : g_flat
      assign is_ext  = 1'b0;
      assign ext_num = '0;
    end
  endgenerate
endmodule

// File: rtl/rr_intr_combiner.sv
module rr_intr_combiner
  import rr_irq_pkg::*;
#(
  parameter int SRC_W   = 64,
  parameter bit CASC_EN = 1'b1,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 13,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_status,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              serviced,
  output logic              irq_out,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_is_ext,
  output logic [IDX_W-1:0]  ext_num
);
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] pend;
  logic [IDX_W-1:0] ptr_q;
  logic             irq_q;

  rr_mask_regs #(.SRC_W(SRC_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .status (src_status),
    .mask   (mask_q),
    .rdata  (reg_rdata)
  );

  assign pend = src_status & mask_q;

  rr_rotate_pick #(.SRC_W(SRC_W)) u_pick (
    .pend  (pend),
    .start (ptr_q),
    .found (idx_valid),
    .pick  (idx)
  );

  rr_casc_remap #(
    .SRC_W(SRC_W), .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
  ) u_remap (
    .valid   (idx_valid),
    .sel     (idx),
    .is_ext  (idx_is_ext),
    .ext_num (ext_num)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= |pend;
      if (serviced && idx_valid) ptr_q <= idx + IDX_W'(1);
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/rr_intr_combiner_chk.sv
module rr_intr_combiner_chk #(
  parameter int SRC_W   = 64,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 13,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input logic             clk,
  input logic             rst,
  input logic [SRC_W-1:0] src_status,
  input logic [SRC_W-1:0] mask_q,
  input logic [IDX_W-1:0] ptr_q,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             serviced,
  input logic             irq_out,
  input logic             idx_valid,
  input logic [IDX_W-1:0] idx,
  input logic             idx_is_ext,
  input logic [IDX_W-1:0] ext_num
);
  logic [SRC_W-1:0] pset;
  logic             skipped;
  logic [IDX_W-1:0] dk, di;

  assign pset = src_status & mask_q;

  always_comb begin
    skipped = 1'b0;
    di = idx - ptr_q;
    dk = '0;
    for (int k = 0; k < SRC_W; k++) begin
      dk = IDX_W'(k) - ptr_q;
      if (pset[k] && (dk < di)) skipped = 1'b1;
    end
  end

  p_idx_pending_r1: assert property (@(posedge clk) disable iff (rst)
    idx_valid |-> pset[idx]);

  p_irq_lag_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq_out == $past(|pset)));

  p_none_r4: assert property (@(posedge clk) disable iff (rst)
    (pset == '0) |-> !idx_valid);

  p_some_r5: assert property (@(posedge clk) disable iff (rst)
    (pset != '0) |-> idx_valid);

  p_first_r5: assert property (@(posedge clk) disable iff (rst)
    idx_valid |-> !skipped);

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (serviced && idx_valid) |=> (ptr_q == $past(idx) + IDX_W'(1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(serviced && idx_valid) |=> $stable(ptr_q));

  p_ext_in_r8: assert property (@(posedge clk) disable iff (rst)
    idx_is_ext |-> (idx >= IDX_W'(CASC_LO) && idx <= IDX_W'(CASC_HI)
                    && ext_num == idx - IDX_W'(CASC_LO)));

  p_ext_out_r8: assert property (@(posedge clk) disable iff (rst)
    (idx_valid && (idx < IDX_W'(CASC_LO) || idx > IDX_W'(CASC_HI)))
      |-> (!idx_is_ext && ext_num == '0));

  p_bit_set_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd4) |=>
      (mask_q == ($past(mask_q) | (SRC_W'(1) << $past(reg_wdata[IDX_W-1:0])))));

  p_bit_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd5) |=>
      (mask_q == ($past(mask_q) & ~(SRC_W'(1) << $past(reg_wdata[IDX_W-1:0])))));
endmodule

bind rr_intr_combiner rr_intr_combiner_chk #(
  .SRC_W(SRC_W), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_status (src_status),
  .mask_q     (mask_q),
  .ptr_q      (ptr_q),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .serviced   (serviced),
  .irq_out    (irq_out),
  .idx_valid  (idx_valid),
  .idx        (idx),
  .idx_is_ext (idx_is_ext),
  .ext_num    (ext_num)
);

// File: tb/sim_rr_intr_combiner.sv
`timescale 1ns/1ps
module sim_rr_intr_combiner;
  localparam int N = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_status = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          serviced = 1'b0;
  logic          irq_out, idx_valid, idx_is_ext;
  logic [IW-1:0] idx, ext_num;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rr_intr_combiner #(.SRC_W(N), .CASC_EN(1'b1), .CASC_LO(8), .CASC_HI(13)) u0 (
    .clk(clk), .rst(rst), .src_status(src_status),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .serviced(serviced), .irq_out(irq_out),
    .idx_valid(idx_valid), .idx(idx), .idx_is_ext(idx_is_ext),
    .ext_num(ext_num)
  );

  // row: status, serviced, exp_valid, exp_idx, exp_ext, exp_num
  localparam int ROWS = 13;
  localparam logic [78:0] TBL [ROWS] = '{
    {64'h0,                   1'b1, 1'b0, 6'd0,  1'b0, 6'd0},
    {64'h28,                  1'b1, 1'b1, 6'd3,  1'b0, 6'd0},
    {64'h28,                  1'b0, 1'b1, 6'd5,  1'b0, 6'd0},
    {64'h28,                  1'b1, 1'b1, 6'd5,  1'b0, 6'd0},
    {64'h28,                  1'b1, 1'b1, 6'd3,  1'b0, 6'd0},
    {64'h8000_0000_0000_0001, 1'b1, 1'b1, 6'd63, 1'b0, 6'd0},
    {64'h8000_0000_0000_0001, 1'b1, 1'b1, 6'd0,  1'b0, 6'd0},
    {64'h0010_0200,           1'b1, 1'b1, 6'd9,  1'b1, 6'd1},
    {64'h6000,                1'b1, 1'b1, 6'd13, 1'b1, 6'd5},
    {64'h6000,                1'b1, 1'b1, 6'd14, 1'b0, 6'd0},
    {64'h100,                 1'b1, 1'b1, 6'd8,  1'b1, 6'd0},
    {64'h0,                   1'b1, 1'b0, 6'd0,  1'b0, 6'd0},
    {64'h280,                 1'b0, 1'b1, 6'd9,  1'b1, 6'd1}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    do_reset();
    // R3: reset state, mask zero blocks everything
    src_status = '1;
    #1;
    chk("R3 idx_valid after reset, mask 0", idx_valid, 1'b0);
    rd_reg(3'd2, rv); chk("R3 mask lo after reset", rv, 32'h0);
    rd_reg(3'd3, rv); chk("R3 mask hi after reset", rv, 32'h0);
    chk("R3 irq_out after reset", irq_out, 1'b0);

    // R11: registered read of status, one clock of latency
    src_status = 64'hA5A5_0000_1234_5678;
    rd_reg(3'd0, rv); chk("R11 status lo read", rv, 32'h1234_5678);
    @(negedge clk);
    reg_addr = 3'd1;
    #1 chk("R11 rdata holds old word before edge", reg_rdata, 32'h1234_5678);
    @(posedge clk);
    #1 chk("R11 status hi read", reg_rdata, 32'hA5A5_0000);
    rd_reg(3'd6, rv); chk("R11 unmapped address reads 0", rv, 32'h0);
    src_status = '0;

    // R9: full-word mask writes
    wr_reg(3'd2, 32'hFFFF_FFFF);
    wr_reg(3'd3, 32'hFFFF_FFFF);
    rd_reg(3'd2, rv); chk("R9 mask lo write", rv, 32'hFFFF_FFFF);
    rd_reg(3'd3, rv); chk("R9 mask hi write", rv, 32'hFFFF_FFFF);

    // R10: single-bit clear and set in the upper word
    wr_reg(3'd5, 32'd40);
    rd_reg(3'd3, rv); chk("R10 clear bit 40", rv, 32'hFFFF_FEFF);
    rd_reg(3'd2, rv); chk("R10 clear leaves low word", rv, 32'hFFFF_FFFF);
    wr_reg(3'd4, 32'd40);
    rd_reg(3'd3, rv); chk("R10 set bit 40", rv, 32'hFFFF_FFFF);

    // R4 R5 R6 R7 R8 R2: walk the vector table
    for (int r = 0; r < ROWS; r++) begin
      logic [78:0] row;
      row = TBL[r];
      @(negedge clk);
      src_status = row[78:15];
      serviced   = row[14];
      #1;
      chk($sformatf("R4 R5 row %0d idx_valid", r), idx_valid, row[13]);
      if (row[13]) begin
        chk($sformatf("R5 R6 R7 row %0d idx", r), idx, row[12:7]);
        chk($sformatf("R8 row %0d idx_is_ext", r), idx_is_ext, row[6]);
        chk($sformatf("R8 row %0d ext_num", r), ext_num, row[5:0]);
      end
      @(posedge clk);
      #1;
      serviced = 1'b0;
      chk($sformatf("R2 row %0d irq_out", r), irq_out, row[13]);
    end

    // R1: masking bit 9 hides it; pointer is at 9, so search wraps to 7
    src_status = 64'h280;
    wr_reg(3'd5, 32'd9);
    rd_reg(3'd2, rv); chk("R10 clear bit 9", rv, 32'hFFFF_FDFF);
    #1;
    chk("R1 masked source skipped", idx, 6'd7);
    chk("R8 index 7 not external", idx_is_ext, 1'b0);
    src_status = 64'h200;
    @(negedge clk); #1;
    chk("R1 only masked source pending: no index", idx_valid, 1'b0);
    @(posedge clk); #1;
    chk("R1 masked source raises no irq", irq_out, 1'b0);

    // R3: reset returns pointer to 0 and clears mask
    do_reset();
    src_status = 64'h1004;
    #1 chk("R3 mask cleared by reset", idx_valid, 1'b0);
    wr_reg(3'd2, 32'hFFFF_FFFF);
    #1 chk("R3 pointer 0 after reset", idx, 6'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule